// File: doc/BRIEF.md
# Dual-Speed Serial Clock Period Generator

This block produces the serial clock for the master side of a two-wire bus. It holds two pairs of period counts, a high and a low count for standard speed and another pair for fast speed. A two-bit speed field in a control register picks which pair times the clock. Software programs the counts and the speed field through a small write-only register port while the generator is stopped, then sets the enable bit to start it. A count for a period is normally chosen as (input clock in kHz × period in tenths of a microsecond / 10000) + 1. For example, a 4.0 µs high time and a 4.7 µs low time suit standard speed, and 0.6 µs high with 1.3 µs low suit fast speed.

The clock line is open-drain. The block therefore outputs a drive-low request and never drives the line high. While the generator is stopped the line is released, so it reads high. Two one-cycle strobes mark each falling and each rising edge that the generator makes, for use by the bit engine.

The sequencer is a three-state machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | Line released. The machine waits for enable. |
| `ST_HIGH` | Line released. The high period is counting down. |
| `ST_LOW` | Line pulled low. The low period is counting down. |

It has four transitions:

| Transition | Condition |
|------------|-----------|
| `ST_IDLE`→`ST_HIGH` | Enable is set. |
| `ST_HIGH`→`ST_LOW` | The high count has expired. The falling strobe fires. |
| `ST_LOW`→`ST_HIGH` | The low count has expired. The rising strobe fires. |
| any→`ST_IDLE` | Enable is cleared. |

Top module: `scl_period_gen`

## Requirements
- R1: Reset forces `scl_drive_low`, `fall_stb` and `rise_stb` to 0 and clears the enable register.
- R2: While the enable register (address 0, bit 0) is 0, `scl_drive_low` stays 0 and both strobes stay 0.
- R3: Enable takes effect on the clock edge after the write that sets it, and the state machine enters `ST_HIGH`. The first high phase lasts the full high count, so `scl_drive_low` first reads 1 on the sample that comes `1 + high` cycles after the write edge.
- R4: A speed field (control register at address 1, bits [2:1]) of any value other than 2'b10, for example control 0x2, selects the standard pair. The line is then low for exactly the standard low count (address 3) and high for exactly the standard high count (address 2), in cycles.
- R5: Control 0x4 (speed field 2'b10) selects the fast pair. The line is then low for the fast low count (address 5) and high for the fast high count (address 4).
- R6: A count register holding 0 times its period as 1 cycle.
- R7: `fall_stb` is 1 for exactly the first cycle of each low phase and 0 in every other cycle.
- R8: `rise_stb` is 1 for exactly the first cycle of each high phase that follows a low phase and 0 in every other cycle.
- R9: Writes to addresses 1 to 5 while enable is 1 are ignored, so the running periods do not change.
- R10: A write that clears enable sends the machine to `ST_IDLE` on the next edge. The line is released from then on and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address: 0 enable, 1 control, 2/3 standard high/low, 4/5 fast high/low |
| wr_data | input | CNT_W (16) | Write data |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| fall_stb | output | 1 | One-cycle strobe in the first cycle of each low phase |
| rise_stb | output | 1 | One-cycle strobe in the first cycle of each high phase after a low phase |

## Verification
The bench builds the block with its default parameters: 16-bit counts and a 3-bit address. This is wide enough for counts up to 47, such as the 40/47 pair, and for the zero and one boundary counts, while each run stays short. The stimulus table covers both speed settings, a zero count on the fast side and on the standard side, and a realistic standard pair. Further directed steps cover reset in mid-run, writes while running, and the release of the line on disable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } scl_state_t;

    localparam int ADR_ENABLE = 0;
    localparam int ADR_CTRL   = 1;
    localparam int ADR_STD_HI = 2;
    localparam int ADR_STD_LO = 3;
    localparam int ADR_FST_HI = 4;
    localparam int ADR_FST_LO = 5;

    localparam logic [1:0] SPEED_FAST = 2'b10;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              run_en,
    output logic [CNT_W-1:0]  hi_len,
    output logic [CNT_W-1:0]  lo_len
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] std_hi_q, std_lo_q, fst_hi_q, fst_lo_q;
    logic [1:0]       speed_q;
    logic [CNT_W-1:0] hi_raw, lo_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            speed_q  <= 2'b00;
            std_hi_q <= '0;
            std_lo_q <= '0;
            fst_hi_q <= '0;
            fst_lo_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_ENABLE)) begin
                run_en <= wr_data[0];
            end else if (!run_en) begin
                unique case (wr_addr)
                    ADDR_W'(ADR_CTRL):   speed_q  <= wr_data[2:1];
                    ADDR_W'(ADR_STD_HI): std_hi_q <= wr_data;
                    ADDR_W'(ADR_STD_LO): std_lo_q <= wr_data;
                    ADDR_W'(ADR_FST_HI): fst_hi_q <= wr_data;
                    ADDR_W'(ADR_FST_LO): fst_lo_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        if (speed_q == SPEED_FAST) begin
            hi_raw = fst_hi_q;
            lo_raw = fst_lo_q;
        end else begin
            hi_raw = std_hi_q;
            lo_raw = std_lo_q;
        end
        hi_len = (hi_raw == '0) ? ONE : hi_raw;
        lo_len = (lo_raw == '0) ? ONE : lo_raw;
    end

    // R9: configuration frozen while running
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wr_en && wr_addr != ADDR_W'(ADR_ENABLE)) |=>
            ($stable(std_hi_q) && $stable(std_lo_q) && $stable(fst_hi_q)
             && $stable(fst_lo_q) && $stable(speed_q)));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             scl_drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!run_en) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_HIGH;
                    cnt_d   = hi_len - ONE;
                end
                ST_HIGH: begin
                    if (cnt_done) begin
                        state_d = ST_LOW;
                        cnt_d   = lo_len - ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                ST_LOW: begin
                    if (cnt_done) begin
                        state_d = ST_HIGH;
                        cnt_d   = hi_len - ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            fall_stb <= (state_q == ST_HIGH) && (state_d == ST_LOW);
            rise_stb <= (state_q == ST_LOW) && (state_d == ST_HIGH);
        end
    end

    assign scl_drive_low = (state_q == ST_LOW);

    // R2 / R10: a cleared enable releases the line on the next edge
    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!scl_drive_low && !fall_stb && !rise_stb));
    // R7: falling strobe only while low, never twice in a row
    p_fall_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_drive_low);
    p_fall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
    // R8: rising strobe only while released
    p_rise_in_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> !scl_drive_low);
    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);
    // R7 / R8: the line changes level only when a strobe would mark it
    p_fall_marks_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $rose(scl_drive_low)) |-> fall_stb);
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              scl_drive_low,
    output logic              fall_stb,
    output logic              rise_stb
);
    logic             run_en;
    logic [CNT_W-1:0] hi_len, lo_len;

    scl_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run_en  (run_en),
        .hi_len  (hi_len),
        .lo_len  (lo_len)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .hi_len        (hi_len),
        .lo_len        (lo_len),
        .scl_drive_low (scl_drive_low),
        .fall_stb      (fall_stb),
        .rise_stb      (rise_stb)
    );

    // R1: outputs quiet during reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!scl_drive_low && !fall_stb && !rise_stb));
endmodule

// File: tb/scl_period_gen_tb_top.sv
module scl_period_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int NVEC   = 5;
    localparam int LIMIT  = 500;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              scl_drive_low, fall_stb, rise_stb;

    int total = 0;
    int bad   = 0;

    // ctrl, std_hi, std_lo, fst_hi, fst_lo, exp_hi, exp_lo
    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] sh;
        logic [15:0] sl;
        logic [15:0] fh;
        logic [15:0] fl;
        logic [15:0] eh;
        logic [15:0] el;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h2, 16'd5,  16'd7,  16'd2, 16'd3,  16'd5,  16'd7},
        '{16'h4, 16'd5,  16'd7,  16'd2, 16'd3,  16'd2,  16'd3},
        '{16'h4, 16'd9,  16'd9,  16'd0, 16'd1,  16'd1,  16'd1},
        '{16'h2, 16'd0,  16'd4,  16'd8, 16'd8,  16'd1,  16'd4},
        '{16'h2, 16'd40, 16'd47, 16'd6, 16'd13, 16'd40, 16'd47}
    };

    scl_period_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .scl_drive_low (scl_drive_low),
        .fall_stb      (fall_stb),
        .rise_stb      (rise_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = CNT_W'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // Samples from the write edge: high samples before the first low,
    // then low run, then high run, with strobe checks.
    task automatic measure_from_enable(output int pre, output int lo, output int hi,
                                       output int fall_ok, output int rise_ok);
        pre = 0; lo = 0; hi = 0; fall_ok = 1; rise_ok = 1;
        @(negedge clk);
        while (!scl_drive_low && pre < LIMIT) begin
            if (fall_stb || rise_stb) fall_ok = 0;
            pre++;
            @(negedge clk);
        end
        if (!fall_stb) fall_ok = 0;
        while (scl_drive_low && lo < LIMIT) begin
            if (lo > 0 && fall_stb) fall_ok = 0;
            if (rise_stb) rise_ok = 0;
            lo++;
            @(negedge clk);
        end
        if (!rise_stb) rise_ok = 0;
        while (!scl_drive_low && hi < LIMIT) begin
            if (hi > 0 && rise_stb) rise_ok = 0;
            if (fall_stb) fall_ok = 0;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic measure_next(output int lo, output int hi);
        int guard = 0;
        lo = 0; hi = 0;
        @(negedge clk);
        while (scl_drive_low && guard < LIMIT) begin guard++; @(negedge clk); end
        while (!scl_drive_low && guard < LIMIT) begin guard++; @(negedge clk); end
        while (scl_drive_low && lo < LIMIT) begin lo++; @(negedge clk); end
        while (!scl_drive_low && hi < LIMIT) begin hi++; @(negedge clk); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pre, lo, hi, fok, rok, quiet;

        // R1: reset state
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R1 drive_low in reset", int'(scl_drive_low), 0);
        check("R1 strobes in reset", int'(fall_stb | rise_stb), 0);
        rst_n = 1'b1;

        // R2: disabled after reset, line stays released
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_drive_low || fall_stb || rise_stb) quiet = 0;
        end
        check("R2 idle released", quiet, 1);

        // table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            wr(0, 0);
            repeat (3) @(negedge clk);
            wr(1, int'(VECS[v].ctrl));
            wr(2, int'(VECS[v].sh));
            wr(3, int'(VECS[v].sl));
            wr(4, int'(VECS[v].fh));
            wr(5, int'(VECS[v].fl));
            wr(0, 1);
            measure_from_enable(pre, lo, hi, fok, rok);
            check(VECS[v].ctrl == 16'h4 ? "R5 fast low" : "R4 std low", lo, int'(VECS[v].el));
            check(VECS[v].ctrl == 16'h4 ? "R5 fast high" : "R4 std high", hi, int'(VECS[v].eh));
            check("R3 first high phase", pre, int'(VECS[v].eh) + 1);
            check("R7 fall strobe", fok, 1);
            check("R8 rise strobe", rok, 1);
            if (v == 2 || v == 3)
                check("R6 zero count as one", hi, 1);
        end

        // R9: writes while running are ignored (running vector 4: std 40/47)
        wr(2, 20);
        wr(3, 9);
        wr(1, 16'h4);
        measure_next(lo, hi);
        check("R9 low unchanged", lo, 47);
        check("R9 high unchanged", hi, 40);

        // R10: disable releases line on the next edge, no strobes
        wr(0, 0);
        @(negedge clk);
        quiet = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (scl_drive_low || fall_stb || rise_stb) quiet = 0;
        end
        check("R10 released after disable", quiet, 1);

        // R9 follow-up: the writes left the stored counts untouched
        wr(1, 16'h2);
        wr(0, 1);
        measure_from_enable(pre, lo, hi, fok, rok);
        check("R9 std low after re-enable", lo, 47);
        check("R9 std high after re-enable", hi, 40);

        // R1: reset while running clears enable
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 drive_low in mid-run reset", int'(scl_drive_low), 0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (scl_drive_low || fall_stb || rise_stb) quiet = 0;
        end
        check("R1 enable cleared by reset", quiet, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule